// File: doc/BRIEF.md
# Memory-Miss-Driven Voltage/Frequency Trigger

This block tells a core's voltage/frequency transition sequencer when to drop to the lowest operating point and when to return to the highest one. The decisions are driven by long-latency off-chip misses. Slack created by a memory access is spent at low voltage. Full speed returns before, or as soon as, the data comes back.

There are two sources of a scale-down. The front end asks for it at once, in the cycle an off-chip instruction-cache miss or an off-chip instruction-translation walk is seen. The dispatch side asks only once dispatch has actually stalled with an off-chip data access (a load miss or a data-translation walk) blocking the head of the reorder buffer. Independent overlapping load misses therefore still issue at full speed.

Only one low-power episode is tracked at a time. In reactive mode the scale-up is requested in the cycle the first outstanding off-chip miss returns. In proactive mode the memory controller reports the remaining latency when it sends the request to a bank. The block then counts down (remaining latency minus ramp time) so that the ramp completes as the data arrives. It fires at once if that difference is not positive.

Top module: `miss_dvfs_trigger`

## Requirements
- R1: While at the high point, a cycle with `ifetch_miss` or `itlb_miss` high raises `scale_down_req` in that same cycle.
- R2: While at the high point, `scale_down_req` is raised in a cycle where `dispatch_stall` is high together with `head_load_offchip` or `head_walk_offchip`. A blocked head without a dispatch stall, or a stall without an off-chip head, raises nothing.
- R3: After a scale-down no further `scale_down_req` is raised until a `scale_up_req` has been issued. `scale_up_req` is never raised while at the high point.
- R4: With `proactive_en` low, latency reports are ignored, and `scale_up_req` is raised exactly in the cycle `miss_return` is seen while scaled down.
- R5: With `proactive_en` high, the first latency report of an episode with `lat_remaining` greater than `ramp_cycles` raises `scale_up_req` exactly `lat_remaining - ramp_cycles` cycles after the report cycle.
- R6: With `proactive_en` high, a first report with `lat_remaining` less than or equal to `ramp_cycles` raises `scale_up_req` in the report cycle itself.
- R7: In either mode, `miss_return` while scaled down raises `scale_up_req` in that cycle, including during a pending countdown, and the countdown is abandoned.
- R8: Latency reports after the first accepted one in an episode, and reports while at the high point, have no effect.
- R9: During reset and right after it the block is at the high point with both request outputs low.
- R10: `scale_down_req` and `scale_up_req` are never high in the same cycle; a scale-down trigger present in the cycle of a scale-up is ignored, and one in the following cycle is honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proactive_en | input | 1 | 1 selects early (latency-based) scale-up, 0 waits for returning data |
| ramp_cycles | input | LAT_W | Cycles the regulator needs to ramp back up |
| ifetch_miss | input | 1 | Off-chip instruction-cache miss detected this cycle |
| itlb_miss | input | 1 | Instruction-translation walk going off-chip detected this cycle |
| dispatch_stall | input | 1 | Dispatch is stalled this cycle |
| head_load_offchip | input | 1 | Reorder-buffer head is a load waiting on off-chip memory |
| head_walk_offchip | input | 1 | Reorder-buffer head waits on an off-chip data-translation walk |
| miss_return | input | 1 | First outstanding off-chip miss returns this cycle |
| lat_valid | input | 1 | Memory controller reports remaining latency this cycle |
| lat_remaining | input | LAT_W | Reported remaining latency in cycles |
| scale_down_req | output | 1 | Pulse: go to the lowest operating point |
| scale_up_req | output | 1 | Pulse: go to the highest operating point |

## Verification
The bench aims at the countdown arithmetic. It sets the remaining latency one above, equal to and below the ramp time. An off-by-one in the load or the zero test would move the scale-up by a cycle, or send a pointless countdown where an immediate request is due. It also drives a blocked head without a stall, and more misses while scaled down. A design that ignored the stall condition, or did not hold a single episode, would issue extra scale-down pulses. Finally it presents a miss return during a countdown, a second report, and a new trigger in the scale-up cycle. A design that mishandled these would keep counting, restart the count, or raise both requests together.

// File: rtl/miss_dvfs_trigger.sv
module miss_dvfs_trigger #(
  parameter int LAT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             proactive_en,
  input  logic [LAT_W-1:0] ramp_cycles,
  input  logic             ifetch_miss,
  input  logic             itlb_miss,
  input  logic             dispatch_stall,
  input  logic             head_load_offchip,
  input  logic             head_walk_offchip,
  input  logic             miss_return,
  input  logic             lat_valid,
  input  logic [LAT_W-1:0] lat_remaining,
  output logic             scale_down_req,
  output logic             scale_up_req
);

  typedef enum logic [1:0] {ST_HIGH, ST_LOW, ST_WAIT} st_t;

  st_t              st_q;
  logic [LAT_W-1:0] cnt_q;

  logic front_trig, load_trig, in_high, rep_ok, short_lat, cnt_done;
  logic [LAT_W-1:0] slack;

  assign front_trig = ifetch_miss | itlb_miss;
  assign load_trig  = dispatch_stall & (head_load_offchip | head_walk_offchip);
  assign in_high    = (st_q == ST_HIGH);
  assign rep_ok     = (st_q == ST_LOW) & proactive_en & lat_valid;
  assign short_lat  = (lat_remaining <= ramp_cycles);
  assign slack      = lat_remaining - ramp_cycles;
  assign cnt_done   = (st_q == ST_WAIT) & (cnt_q == '0);

  assign scale_down_req = in_high & (front_trig | load_trig);
  assign scale_up_req   = ~in_high & (miss_return | (rep_ok & short_lat) | cnt_done);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_HIGH;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_HIGH: if (scale_down_req) st_q <= ST_LOW;
        ST_LOW: begin
          if (scale_up_req) st_q <= ST_HIGH;
          else if (rep_ok) begin
            st_q  <= ST_WAIT;
            cnt_q <= slack - 1'b1;
          end
        end
        ST_WAIT: begin
          if (scale_up_req) st_q <= ST_HIGH;
          else cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= ST_HIGH;
      endcase
    end
  end

endmodule

// File: rtl/miss_dvfs_trigger_chk.sv
module miss_dvfs_trigger_chk #(
  parameter int LAT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             proactive_en,
  input logic [LAT_W-1:0] ramp_cycles,
  input logic             ifetch_miss,
  input logic             itlb_miss,
  input logic             dispatch_stall,
  input logic             head_load_offchip,
  input logic             head_walk_offchip,
  input logic             miss_return,
  input logic             lat_valid,
  input logic [LAT_W-1:0] lat_remaining,
  input logic             scale_down_req,
  input logic             scale_up_req
);

  logic low_q, rep_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_q <= 1'b0;
      rep_q <= 1'b0;
    end else begin
      if (scale_down_req) begin
        low_q <= 1'b1;
        rep_q <= 1'b0;
      end else if (scale_up_req) begin
        low_q <= 1'b0;
        rep_q <= 1'b0;
      end else if (low_q && proactive_en && lat_valid) begin
        rep_q <= 1'b1;
      end
    end
  end

  p_front_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!low_q && (ifetch_miss || itlb_miss)) |-> scale_down_req);

  p_stall_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!low_q && dispatch_stall && (head_load_offchip || head_walk_offchip)) |-> scale_down_req);

  p_down_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    scale_down_req |-> (ifetch_miss || itlb_miss ||
                        (dispatch_stall && (head_load_offchip || head_walk_offchip))));

  p_one_episode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    scale_down_req |-> !low_q);

  p_up_needs_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    scale_up_req |-> low_q);

  p_reactive_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (scale_up_req && !miss_return) |-> (rep_q || (proactive_en && lat_valid)));

  p_short_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (low_q && !rep_q && proactive_en && lat_valid && (lat_remaining <= ramp_cycles))
      |-> scale_up_req);

  p_return_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (low_q && miss_return) |-> scale_up_req);

  p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scale_down_req, scale_up_req}));

  always_comb begin
    if (!rst_n) p_reset_quiet_r9: assert (!scale_up_req);
  end

endmodule

bind miss_dvfs_trigger miss_dvfs_trigger_chk #(.LAT_W(LAT_W)) chk_i (.*);

// File: tb/miss_dvfs_trigger_tb_top.sv
`timescale 1ns/1ps
module miss_dvfs_trigger_tb_top;
  localparam int LAT_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic proactive_en = 1'b0;
  logic [LAT_W-1:0] ramp_cycles = 12'd20;
  logic ifetch_miss = 0, itlb_miss = 0, dispatch_stall = 0;
  logic head_load_offchip = 0, head_walk_offchip = 0;
  logic miss_return = 0, lat_valid = 0;
  logic [LAT_W-1:0] lat_remaining = '0;
  logic scale_down_req, scale_up_req;

  always #4 clk = ~clk;

  miss_dvfs_trigger #(.LAT_W(LAT_W)) dut_i (.*);

  int tests = 0, fails = 0;
  int cyc = 0;
  bit m_low = 0, m_rep = 0;
  int m_deadline = -1;
  int ups = 0, downs = 0;
  string tag = "R9";

  task automatic check(string t, logic act, logic exp, string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b cycle=%0d", t, what, act, exp, cyc);
    end
  endtask

  task automatic tick();
    bit ed, eu;
    @(negedge clk);
    if (!rst_n) begin
      ed = 0; eu = 0;
    end else begin
      ed = !m_low && (ifetch_miss || itlb_miss ||
           (dispatch_stall && (head_load_offchip || head_walk_offchip)));
      eu = m_low && (miss_return ||
           (proactive_en && lat_valid && !m_rep && (lat_remaining <= ramp_cycles)) ||
           (m_rep && m_deadline == cyc));
    end
    check(tag, scale_down_req, ed, "scale_down_req");
    check(tag, scale_up_req, eu, "scale_up_req");
    if (scale_up_req === 1'b1) ups++;
    if (scale_down_req === 1'b1) downs++;
    if (!rst_n) begin
      m_low = 0; m_rep = 0; m_deadline = -1;
    end else if (ed) begin
      m_low = 1; m_rep = 0; m_deadline = -1;
    end else if (eu) begin
      m_low = 0; m_rep = 0; m_deadline = -1;
    end else if (m_low && proactive_en && lat_valid && !m_rep) begin
      m_rep = 1;
      m_deadline = cyc + int'(lat_remaining) - int'(ramp_cycles);
    end
    cyc++;
    @(posedge clk); #1;
    ifetch_miss = 0; itlb_miss = 0; miss_return = 0; lat_valid = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic report(int rem);
    lat_valid = 1; lat_remaining = rem[LAT_W-1:0];
  endtask

  // count scale-ups over a window and check where the single one lands
  task automatic expect_up_at(string t, int n_wait);
    int start;
    start = ups;
    idle(n_wait - 1);
    check(t, logic'(ups != start), 1'b0, "early scale_up_req");
    tick();
    check(t, logic'(ups == start + 1), 1'b1, "scale_up_req at deadline");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : stim
    int d0;
    tag = "R9"; idle(3);
    rst_n = 1; idle(3);

    tag = "R1"; ifetch_miss = 1; tick(); idle(4);
    tag = "R3"; ifetch_miss = 1; tick(); itlb_miss = 1; tick(); idle(2);
    tag = "R4"; miss_return = 1; tick(); idle(2);
    tag = "R3"; miss_return = 1; tick(); idle(2);
    tag = "R1"; itlb_miss = 1; tick(); idle(3); miss_return = 1; tick(); idle(2);

    tag = "R2"; head_load_offchip = 1; idle(4);
    dispatch_stall = 1; head_load_offchip = 0; idle(3);
    head_load_offchip = 1; d0 = downs; tick();
    check("R2", logic'(downs == d0 + 1), 1'b1, "stall down count");
    idle(3); dispatch_stall = 0; head_load_offchip = 0;
    miss_return = 1; tick(); idle(2);
    dispatch_stall = 1; head_walk_offchip = 1; tick();
    dispatch_stall = 0; head_walk_offchip = 0; idle(2);

    tag = "R4"; report(3); tick(); idle(5);
    d0 = ups; idle(5);
    check("R4", logic'(ups == d0), 1'b1, "no up without return");
    miss_return = 1; tick(); idle(2);

    proactive_en = 1;
    tag = "R5"; ifetch_miss = 1; tick(); report(50); tick();
    expect_up_at("R5", 30); idle(2);
    ifetch_miss = 1; tick(); report(21); tick();
    expect_up_at("R5", 1); idle(2);

    tag = "R6"; ifetch_miss = 1; tick(); idle(2);
    report(20); d0 = ups; tick();
    check("R6", logic'(ups == d0 + 1), 1'b1, "equal latency immediate");
    idle(2);
    ifetch_miss = 1; tick(); report(5); tick(); idle(2);

    tag = "R8"; report(100); tick(); idle(2);
    ifetch_miss = 1; tick(); report(40); tick(); idle(3);
    report(2); d0 = ups; tick();
    check("R8", logic'(ups == d0), 1'b1, "second report ignored");
    expect_up_at("R8", 16); idle(2);

    tag = "R7"; ifetch_miss = 1; tick(); report(80); tick(); idle(10);
    miss_return = 1; tick(); idle(70);
    check("R7", m_low, 1'b0, "episode closed");

    tag = "R10"; ifetch_miss = 1; tick(); idle(2);
    miss_return = 1; ifetch_miss = 1; d0 = downs; tick();
    check("R10", logic'(downs == d0), 1'b1, "trigger in up cycle ignored");
    ifetch_miss = 1; tick();
    check("R10", logic'(downs == d0 + 1), 1'b1, "trigger next cycle honoured");
    miss_return = 1; tick(); idle(3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule